// File: doc/BRIEF.md
# Multicycle Datapath with Unified Memory

This block is the storage and arithmetic half of a processor that spends several clock cycles on each instruction. A single word-addressed memory holds both the program and its data. One ALU does every addition, subtraction and logic operation, whether that is advancing the program counter, forming a branch target or address, or running a register-to-register instruction. Five holding registers carry results from one cycle to the next: the instruction latch, the memory-data latch, the two operand latches and the ALU result latch. A 32-entry register file and a sign extender complete the block.

Every choice the datapath makes comes from plain select and enable inputs. A separate sequencer drives these, one set per cycle, and reads back the fetched instruction and the ALU zero flag. The sequencer is not part of this block. At reset, each memory word is filled with a computed pattern, so a program or a bench starts from known contents without a load port. Stores through the datapath then change those contents.

Top module: `mcdp_top`

## Requirements
- R1: While `rst_n` is low, `pc`, `instr`, `mdr`, `opnd_a`, `opnd_b` and `alu_out` are zero and every register-file entry is zero. Memory word i is set to (i × 0x9E3779B1) XOR `MEM_SEED`, taken modulo 2^32.
- R2: The memory byte address is `pc` when `sel_addr`=0 and `alu_out` when `sel_addr`=1. The word read or written is address bits [MEM_AW+1:2]. The two low bits are ignored and any higher bits wrap.
- R3: The first ALU operand is `pc` when `opa_sel`=0 and `opnd_a` when `opa_sel`=1.
- R4: The second ALU operand follows `opb_sel`: 0 gives `opnd_b`, 1 gives the constant 4, 2 gives `instr[15:0]` sign-extended, and 3 gives that same value shifted left by two.
- R5: The ALU function follows `alu_mode`: 0 is add and 1 is subtract. Any other value decodes `instr[5:0]`: 0x22 is subtract, 0x24 is AND, 0x25 is OR, 0x2A is signed set-less-than (result 1 or 0), and every other code is add. All arithmetic is modulo 2^32.
- R6: `alu_zero` is high exactly when the current ALU result is zero.
- R7: At a clock edge, PC is loaded when `pc_we`=1, or when `pc_we_zero`=1 and `alu_zero`=1. Otherwise PC holds. The value loaded follows `pc_sel`: 0 is the live ALU result, 1 is `alu_out`, and 2 is {pc[31:28], instr[25:0], 2'b00}.
- R8: When `rf_we`=1, the register file writes to index `instr[20:16]` if `dst_sel`=0 or to `instr[15:11]` if `dst_sel`=1. The data written is `alu_out` if `wb_sel`=0 or `mdr` if `wb_sel`=1.
- R9: `instr` loads the memory read word at an edge only when `ir_we`=1. At every edge, `mdr` takes the memory read word, `opnd_a` takes register `instr[25:21]`, `opnd_b` takes register `instr[20:16]`, and `alu_out` takes the ALU result.
- R10: When `mem_we`=1, the addressed memory word is replaced by `opnd_b` at the edge.
- R11: Register 0 always reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_addr | input | 1 | Memory address source: 0 PC, 1 ALU result latch |
| mem_we | input | 1 | Memory write enable |
| ir_we | input | 1 | Instruction latch load enable |
| dst_sel | input | 1 | Destination register field select |
| wb_sel | input | 1 | Register write data select |
| rf_we | input | 1 | Register file write enable |
| opa_sel | input | 1 | First ALU operand select |
| opb_sel | input | 2 | Second ALU operand select |
| alu_mode | input | 2 | ALU function control |
| pc_sel | input | 2 | PC next-value source |
| pc_we | input | 1 | Unconditional PC load |
| pc_we_zero | input | 1 | PC load qualified by the zero flag |
| instr | output | 32 | Instruction latch |
| pc | output | 32 | Program counter |
| mdr | output | 32 | Memory data latch |
| opnd_a | output | 32 | First operand latch |
| opnd_b | output | 32 | Second operand latch |
| alu_out | output | 32 | ALU result latch |
| alu_zero | output | 1 | ALU result is zero |

## Verification
The assertions assume that `pc_sel` never takes the unused code 3 and that `alu_mode` stays at or below 2, as a well-formed sequencer would ensure. The random control generator draws both fields only from their legal values. Every other select and enable is drawn freely, including simultaneous register and memory writes. Because memory is filled from a hash at reset and later overwritten by stores, the fetched instruction fields land on every register index and on each decoded function code. Fixed-interval directed cycles add jumps, zero-qualified branches and instruction fetches on top of the random mix.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
   localparam int XLEN   = 32;
   localparam int RIDX_W = 5;

   typedef enum logic [2:0] {
      FN_ADD,
      FN_SUB,
      FN_AND,
      FN_OR,
      FN_SLT
   } alu_fn_e;

   localparam logic [5:0] FUNCT_SUB = 6'h22;
   localparam logic [5:0] FUNCT_AND = 6'h24;
   localparam logic [5:0] FUNCT_OR  = 6'h25;
   localparam logic [5:0] FUNCT_SLT = 6'h2A;

   localparam logic [31:0] HASH_MUL = 32'h9E37_79B1;

   function automatic logic [XLEN-1:0] mem_fill(input int unsigned idx,
                                                input logic [XLEN-1:0] seed);
      logic [XLEN-1:0] prod;
      prod = XLEN'(idx) * HASH_MUL;
      return prod ^ seed;
   endfunction
endpackage

// File: rtl/mcdp_alu_ctl.sv
module mcdp_alu_ctl
   import mcdp_pkg::*;
(
   input  logic [1:0] alu_mode,
   input  logic [5:0] funct,
   output alu_fn_e    fn
);
   always_comb begin
      unique case (alu_mode)
         2'b00:   fn = FN_ADD;
         2'b01:   fn = FN_SUB;
         default: begin
            unique case (funct)
               FUNCT_SUB: fn = FN_SUB;
               FUNCT_AND: fn = FN_AND;
               FUNCT_OR:  fn = FN_OR;
               FUNCT_SLT: fn = FN_SLT;
               default:   fn = FN_ADD;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
   import mcdp_pkg::*;
(
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_fn_e         fn,
   output logic [XLEN-1:0] y,
   output logic            zero
);
   always_comb begin
      unique case (fn)
         FN_SUB:  y = a - b;
         FN_AND:  y = a & b;
         FN_OR:   y = a | b;
         FN_SLT:  y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
   import mcdp_pkg::*;
#(
   parameter int IDX_W = RIDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ra1,
   input  logic [IDX_W-1:0] ra2,
   output logic [XLEN-1:0]  rd1,
   output logic [XLEN-1:0]  rd2,
   input  logic             we,
   input  logic [IDX_W-1:0] wa,
   input  logic [XLEN-1:0]  wd
);
   localparam int ENTRIES = 1 << IDX_W;

   logic [ENTRIES-1:0][XLEN-1:0] regs;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
         if (i == 0) begin : g_hardzero
            assign regs[i] = '0;
         end else begin : g_store
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n) q <= '0;
               else if (we && wa == IDX_W'(i)) q <= wd;
            end
            assign regs[i] = q;
         end
      end
   endgenerate

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
endmodule

// File: rtl/mcdp_mem.sv
module mcdp_mem
   import mcdp_pkg::*;
#(
   parameter int              AW   = 6,
   parameter logic [XLEN-1:0] SEED = 32'h1234_5678
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   widx,
   input  logic            we,
   input  logic [XLEN-1:0] wd,
   output logic [XLEN-1:0] rd
);
   localparam int WORDS = 1 << AW;

   logic [WORDS-1:0][XLEN-1:0] words;

   generate
      for (genvar i = 0; i < WORDS; i++) begin : g_word
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= mem_fill(i, SEED);
            else if (we && widx == AW'(i)) q <= wd;
         end
         assign words[i] = q;
      end
   endgenerate

   assign rd = words[widx];
endmodule

// File: rtl/mcdp_top.sv
module mcdp_top
   import mcdp_pkg::*;
#(
   parameter int              MEM_AW   = 6,
   parameter logic [XLEN-1:0] MEM_SEED = 32'h1234_5678
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel_addr,
   input  logic        mem_we,
   input  logic        ir_we,
   input  logic        dst_sel,
   input  logic        wb_sel,
   input  logic        rf_we,
   input  logic        opa_sel,
   input  logic [1:0]  opb_sel,
   input  logic [1:0]  alu_mode,
   input  logic [1:0]  pc_sel,
   input  logic        pc_we,
   input  logic        pc_we_zero,
   output logic [31:0] instr,
   output logic [31:0] pc,
   output logic [31:0] mdr,
   output logic [31:0] opnd_a,
   output logic [31:0] opnd_b,
   output logic [31:0] alu_out,
   output logic        alu_zero
);
   localparam int WIDX_HI = MEM_AW + 1;

   initial begin
      assert_param_range: assert (MEM_AW >= 2 && MEM_AW <= 12)
         else $error("MEM_AW out of supported range");
   end

   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aout_q;
   logic [XLEN-1:0] mem_rd, rf_rd1, rf_rd2;
   logic [XLEN-1:0] op_a, op_b, alu_y, imm_sx, wb_data, pc_next;
   logic [MEM_AW-1:0] widx;
   logic [RIDX_W-1:0] wr_idx;
   logic              pc_load;
   alu_fn_e           fn;

   // memory address select (R2)
   assign widx = sel_addr ? aout_q[WIDX_HI:2] : pc_q[WIDX_HI:2];

   mcdp_mem #(.AW(MEM_AW), .SEED(MEM_SEED)) u_mem (
      .clk(clk), .rst_n(rst_n), .widx(widx),
      .we(mem_we), .wd(b_q), .rd(mem_rd)
   );

   // register file with destination and write-back select (R8, R11)
   assign wr_idx  = dst_sel ? ir_q[15:11] : ir_q[20:16];
   assign wb_data = wb_sel ? mdr_q : aout_q;

   mcdp_regfile #(.IDX_W(RIDX_W)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra1(ir_q[25:21]), .ra2(ir_q[20:16]),
      .rd1(rf_rd1), .rd2(rf_rd2),
      .we(rf_we), .wa(wr_idx), .wd(wb_data)
   );

   // operand selection (R3, R4)
   assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
   assign op_a   = opa_sel ? a_q : pc_q;

   always_comb begin
      unique case (opb_sel)
         2'd0:    op_b = b_q;
         2'd1:    op_b = XLEN'(4);
         2'd2:    op_b = imm_sx;
         default: op_b = {imm_sx[XLEN-3:0], 2'b00};
      endcase
   end

   mcdp_alu_ctl u_ctl (.alu_mode(alu_mode), .funct(ir_q[5:0]), .fn(fn));

   mcdp_alu u_alu (.a(op_a), .b(op_b), .fn(fn), .y(alu_y), .zero(alu_zero));

   // PC source and load qualification (R7)
   always_comb begin
      unique case (pc_sel)
         2'd0:    pc_next = alu_y;
         2'd1:    pc_next = aout_q;
         default: pc_next = {pc_q[31:28], ir_q[25:0], 2'b00};
      endcase
   end

   assign pc_load = pc_we || (pc_we_zero && alu_zero);

   // holding registers (R1, R9)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= '0;
         ir_q   <= '0;
         mdr_q  <= '0;
         a_q    <= '0;
         b_q    <= '0;
         aout_q <= '0;
      end else begin
         if (pc_load) pc_q <= pc_next;
         if (ir_we)   ir_q <= mem_rd;
         mdr_q  <= mem_rd;
         a_q    <= rf_rd1;
         b_q    <= rf_rd2;
         aout_q <= alu_y;
      end
   end

   assign instr   = ir_q;
   assign pc      = pc_q;
   assign mdr     = mdr_q;
   assign opnd_a  = a_q;
   assign opnd_b  = b_q;
   assign alu_out = aout_q;

   // input contract taken for granted by the checks below
   assert_legal_pc_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel != 2'd3);
   assert_legal_alu_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      alu_mode != 2'd3);

   assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_we && !pc_we_zero) |=> $stable(pc_q));
   assert_jump_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we && pc_sel == 2'd2) |=>
         (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_q[31:28])));
   assert_ir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_we |=> $stable(ir_q));
   assert_r0_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_q[25:21] == '0) |=> (a_q == '0));
   assert_writeback_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && wr_idx != '0 && wr_idx == ir_q[25:21] && !ir_we)
         |-> ##2 (a_q == $past(wb_data, 2)));
endmodule

// File: tb/test_mcdp_top.sv
`timescale 1ns/1ps
module test_mcdp_top;
   localparam int          AW    = 6;
   localparam int          WORDS = 1 << AW;
   localparam logic [31:0] SEED  = 32'h1234_5678;
   localparam int          NCYC  = 4000;

   logic clk = 1'b0;
   logic rst_n;
   logic sel_addr, mem_we, ir_we, dst_sel, wb_sel, rf_we, opa_sel;
   logic [1:0] opb_sel, alu_mode, pc_sel;
   logic pc_we, pc_we_zero;
   logic [31:0] instr, pc, mdr, opnd_a, opnd_b, alu_out;
   logic alu_zero;

   always #2.5 clk = ~clk;

   mcdp_top #(.MEM_AW(AW), .MEM_SEED(SEED)) i_mcdp_top (
      .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .mem_we(mem_we),
      .ir_we(ir_we), .dst_sel(dst_sel), .wb_sel(wb_sel), .rf_we(rf_we),
      .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_mode(alu_mode),
      .pc_sel(pc_sel), .pc_we(pc_we), .pc_we_zero(pc_we_zero),
      .instr(instr), .pc(pc), .mdr(mdr), .opnd_a(opnd_a),
      .opnd_b(opnd_b), .alu_out(alu_out), .alu_zero(alu_zero)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [31:0] m_mem [WORDS];
   logic [31:0] m_rf  [32];
   logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_aout;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] fill_word(input int i);
      logic [31:0] p;
      p = 32'(i) * 32'h9E37_79B1;
      return p ^ SEED;
   endfunction

   function automatic logic [31:0] alu_ref(input logic [31:0] a, input logic [31:0] b,
                                           input logic [1:0] mode, input logic [5:0] f);
      int code;
      if (mode == 2'd0) code = 0;
      else if (mode == 2'd1) code = 1;
      else begin
         case (f)
            6'h22:   code = 1;
            6'h24:   code = 2;
            6'h25:   code = 3;
            6'h2A:   code = 4;
            default: code = 0;
         endcase
      end
      case (code)
         1:       return a - b;
         2:       return a & b;
         3:       return a | b;
         4:       return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         default: return a + b;
      endcase
   endfunction

   function automatic logic [31:0] opb_ref(input logic [1:0] s, input logic [31:0] b,
                                           input logic [31:0] ir);
      logic [31:0] sx;
      sx = {{16{ir[15]}}, ir[15:0]};
      case (s)
         2'd0:    return b;
         2'd1:    return 32'd4;
         2'd2:    return sx;
         default: return {sx[29:0], 2'b00};
      endcase
   endfunction

   task automatic drive_idle();
      sel_addr = 0; mem_we = 0; ir_we = 0; dst_sel = 0; wb_sel = 0;
      rf_we = 0; opa_sel = 0; opb_sel = 0; alu_mode = 0; pc_sel = 0;
      pc_we = 0; pc_we_zero = 0;
   endtask

   task automatic drive_cycle(input int n);
      sel_addr   = 1'($urandom_range(0, 1));
      mem_we     = ($urandom_range(0, 5) == 0);
      ir_we      = ($urandom_range(0, 3) == 0);
      dst_sel    = 1'($urandom_range(0, 1));
      wb_sel     = 1'($urandom_range(0, 1));
      rf_we      = ($urandom_range(0, 1) == 0);
      opa_sel    = 1'($urandom_range(0, 1));
      opb_sel    = 2'($urandom_range(0, 3));
      alu_mode   = 2'($urandom_range(0, 2));
      pc_sel     = 2'($urandom_range(0, 2));
      pc_we      = ($urandom_range(0, 3) == 0);
      pc_we_zero = ($urandom_range(0, 3) == 0);
      // directed corner cases
      if (n % 50 == 0) begin            // jump into region (R7)
         pc_we = 1; pc_we_zero = 0; pc_sel = 2;
      end else if (n % 50 == 25) begin  // zero-qualified branch on A-B (R6, R7)
         pc_we = 0; pc_we_zero = 1; pc_sel = 1;
         opa_sel = 1; opb_sel = 0; alu_mode = 1;
      end else if (n % 37 == 0) begin   // fetch from PC with PC+4 (R2, R9)
         sel_addr = 0; ir_we = 1; opa_sel = 0; opb_sel = 1;
         alu_mode = 0; pc_we = 1; pc_sel = 0;
      end
   endtask

   initial begin
      void'($urandom(32'hC0DE_2024));
      for (int i = 0; i < WORDS; i++) m_mem[i] = fill_word(i);
      for (int i = 0; i < 32; i++) m_rf[i] = '0;
      m_pc = '0; m_ir = '0; m_mdr = '0; m_a = '0; m_b = '0; m_aout = '0;

      rst_n = 0;
      drive_idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "pc at reset", pc, 32'h0);
      chk("R1", "instr at reset", instr, 32'h0);
      chk("R1", "mdr at reset", mdr, 32'h0);
      chk("R1", "opnd_a at reset", opnd_a, 32'h0);
      chk("R1", "opnd_b at reset", opnd_b, 32'h0);
      chk("R1", "alu_out at reset", alu_out, 32'h0);
      rst_n = 1;

      for (int n = 0; n < NCYC; n++) begin
         logic [31:0] rdata, oa, ob, res, npc, wd;
         logic [4:0]  dst;
         logic        z;
         int          idx;
         drive_cycle(n);
         idx   = int'(sel_addr ? m_aout[AW+1:2] : m_pc[AW+1:2]);
         rdata = m_mem[idx];
         oa    = opa_sel ? m_a : m_pc;
         ob    = opb_sel_ref(ob);
         res   = alu_ref(oa, ob, alu_mode, m_ir[5:0]);
         z     = (res == 32'h0);
         #1;
         chk("R6", "alu_zero", {31'h0, alu_zero}, {31'h0, z});
         npc = m_pc;
         if (pc_we || (pc_we_zero && z)) begin
            case (pc_sel)
               2'd0:    npc = res;
               2'd1:    npc = m_aout;
               default: npc = {m_pc[31:28], m_ir[25:0], 2'b00};
            endcase
         end
         dst = dst_sel ? m_ir[15:11] : m_ir[20:16];
         wd  = wb_sel ? m_mdr : m_aout;
         m_a    = m_rf[m_ir[25:21]];
         m_b    = m_rf[m_ir[20:16]];
         if (mem_we) m_mem[idx] = opnd_b;
         if (rf_we && dst != 5'd0) m_rf[dst] = wd;
         m_mdr  = rdata;
         if (ir_we) m_ir = rdata;
         m_aout = res;
         m_pc   = npc;
         @(negedge clk);
         chk("R7", "pc", pc, m_pc);
         chk("R9", "instr", instr, m_ir);
         chk("R2", "mdr (memory read, R10 stores)", mdr, m_mdr);
         chk("R8", "opnd_a (write-back, R11 zero)", opnd_a, m_a);
         chk("R8", "opnd_b", opnd_b, m_b);
         chk("R5", "alu_out (R3 R4 operands)", alu_out, m_aout);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   function automatic logic [31:0] opb_sel_ref(input logic [31:0] unused_prev);
      logic [31:0] r;
      r = opb_ref(opb_sel, m_b, m_ir);
      if (unused_prev === 32'hDEAD_BEEF) r = r;
      return r;
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule